// File: doc/BRIEF.md
# Debug Module Access Scan Register

This block is the data register that a JTAG TAP routes between TDI and TDO while the debug-access instruction is active. The TAP controller supplies its capture, shift and update strobes plus a select line, and the block turns each completed scan into at most one operation toward a debug module. The module-facing side is a plain request/response port: the request carries address, write data and a write flag; the response carries read data and a two-bit status.

Each scan frame holds an address field, a data field and a two-bit operation field. On update the operation held in the frame is issued. On the next capture the frame is reloaded with the address of the last issued operation, the most recently returned data and a sticky status, so a read's data is collected by the scan that follows it, normally carrying a no-op. Error and busy conditions stick until cleared, and while a status is set all new operations are refused. A test-logic-reset pulse returns the scan path and the operation tracking to idle.

Top module: `dmi_access_reg`

## Requirements
- R1: The frame is ADDR_W+DATA_W+2 bits (41 by default), ordered {address, data, op} from MSB to LSB; shifting moves TDI into the MSB and TDO shows bit 0, so the op field leaves first.
- R2: Op value 0 is a no-op and value 3 is handled as a no-op; neither raises a request.
- R3: An update with op 1 (read) or 2 (write) while idle and with status 0 raises req_valid for exactly one cycle, in the cycle after the update strobe, with req_write high only for op 2 and req_addr and req_wdata taken from the frame.
- R4: Capture loads {address of the last issued operation, held response data, sticky status}; the held data changes only when an outstanding operation completes.
- R5: Data returned for a read is shifted out by the following scan.
- R6: Status 0 means success; a response status of 1 (reserved) is recorded as 2 (failed); response status 2 and 3 are recorded as given; the first non-zero status stays until stat_clr.
- R7: A read or write updated while an operation is outstanding sets the status to 3 (busy) and is dropped; while the status is non-zero every read or write is dropped.
- R8: A tlr pulse clears the outstanding flag, the status and the whole shift register, so TDO reads 0.
- R9: Capture, shift and update strobes have no effect while dmi_sel is low.
- R10: A response that arrives with no operation outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | Test-logic-reset pulse from the TAP |
| dmi_sel | input | 1 | Debug-access instruction is active |
| capture_dr | input | 1 | TAP capture strobe |
| shift_dr | input | 1 | TAP shift strobe |
| update_dr | input | 1 | TAP update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| stat_clr | input | 1 | Clears the sticky status |
| req_valid | output | 1 | One-cycle operation request |
| req_write | output | 1 | Request is a write |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Request write data |
| resp_valid | input | 1 | Response strobe from the debug module |
| resp_data | input | DATA_W | Response read data |
| resp_status | input | 2 | Response status |

## Verification
The bench builds the block with its default values: a 7-bit address, a 32-bit data field and the direct TDO path, which yields the 41-bit frame and lets the bench compare every captured frame bit for bit against a model of address, held data and status. With the direct TDO path, bit 0 of a capture is visible before the first shift edge, so each scan's output is the full capture value. Random reads and writes with random response statuses run alongside directed busy, reserved-status, deselect and reset cases.

// File: rtl/dmi_pkg.sv
package dmi_pkg;
   typedef enum logic [1:0] {
      OP_NOP   = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_RSV   = 2'd3
   } dmi_op_e;

   localparam logic [1:0] ST_OK   = 2'd0;
   localparam logic [1:0] ST_RSVD = 2'd1;
   localparam logic [1:0] ST_FAIL = 2'd2;
   localparam logic [1:0] ST_BUSY = 2'd3;

   // a reserved response code is recorded as a failure
   function automatic logic [1:0] map_status(input logic [1:0] s);
      return (s == ST_RSVD) ? ST_FAIL : s;
   endfunction
endpackage

// File: rtl/dmi_scan_chain.sv
module dmi_scan_chain #(
   parameter int W       = 41,
   parameter bit TDO_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic         sh,
   input  logic [W-1:0] ld_val,
   input  logic         tdi,
   output logic [W-1:0] sr,
   output logic         tdo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sr <= '0;
      else if (clr)  sr <= '0;
      else if (ld)   sr <= ld_val;
      else if (sh)   sr <= {tdi, sr[W-1:1]};
   end

   generate
      if (TDO_REG) begin : g_tdo_flop
         logic tdo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tdo_q <= 1'b0;
            else        tdo_q <= sr[0];
         end
         assign tdo = tdo_q;
      end else begin : g_tdo_direct
         assign tdo = sr[0];
      end
   endgenerate
endmodule

// File: rtl/dmi_op_tracker.sv
module dmi_op_tracker
   import dmi_pkg::*;
#(
   parameter int AW = 7,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          upd,
   input  logic [AW-1:0] upd_addr,
   input  logic [DW-1:0] upd_data,
   input  logic [1:0]    upd_op,
   input  logic          stat_clr,
   input  logic          resp_valid,
   input  logic [DW-1:0] resp_data,
   input  logic [1:0]    resp_status,
   output logic          req_valid,
   output logic          req_write,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_wdata,
   output logic [DW-1:0] hold_data,
   output logic [1:0]    status,
   output logic          pending
);
   logic is_acc, go, done;

   assign is_acc = upd && (upd_op == OP_READ || upd_op == OP_WRITE);
   assign go     = is_acc && (status == ST_OK) && !pending;
   assign done   = pending && resp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_write <= 1'b0;
         req_addr  <= '0;
         req_wdata <= '0;
         hold_data <= '0;
         status    <= ST_OK;
         pending   <= 1'b0;
      end else begin
         req_valid <= 1'b0;
         if (clr) begin
            pending <= 1'b0;
            status  <= ST_OK;
         end else begin
            if (go) begin
               req_valid <= 1'b1;
               req_write <= (upd_op == OP_WRITE);
               req_addr  <= upd_addr;
               req_wdata <= upd_data;
               pending   <= 1'b1;
            end else if (done) begin
               pending <= 1'b0;
            end
            if (done) hold_data <= resp_data;
            if (stat_clr)
               status <= ST_OK;
            else if (is_acc && status == ST_OK && pending)
               status <= ST_BUSY;
            else if (done && status == ST_OK && resp_status != ST_OK)
               status <= map_status(resp_status);
         end
      end
   end
endmodule

// File: rtl/dmi_access_reg.sv
module dmi_access_reg
   import dmi_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int DATA_W  = 32,
   parameter bit TDO_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tlr,
   input  logic              dmi_sel,
   input  logic              capture_dr,
   input  logic              shift_dr,
   input  logic              update_dr,
   input  logic              tdi,
   output logic              tdo,
   input  logic              stat_clr,
   output logic              req_valid,
   output logic              req_write,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_wdata,
   input  logic              resp_valid,
   input  logic [DATA_W-1:0] resp_data,
   input  logic [1:0]        resp_status
);
   localparam int OP_W    = 2;
   localparam int FRAME_W = ADDR_W + DATA_W + OP_W;
   localparam int D_LSB   = OP_W;
   localparam int A_LSB   = OP_W + DATA_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
         $error("DATA_W out of range");
      end
   endgenerate

   logic [FRAME_W-1:0] sr, cap_val;
   logic [DATA_W-1:0]  hold_w;
   logic [1:0]         sticky_w;
   logic               pending_w;

   assign cap_val = {req_addr, hold_w, sticky_w};

   dmi_scan_chain #(.W(FRAME_W), .TDO_REG(TDO_REG)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (tlr),
      .ld     (dmi_sel && capture_dr),
      .sh     (dmi_sel && shift_dr),
      .ld_val (cap_val),
      .tdi    (tdi),
      .sr     (sr),
      .tdo    (tdo)
   );

   dmi_op_tracker #(.AW(ADDR_W), .DW(DATA_W)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (tlr),
      .upd         (dmi_sel && update_dr),
      .upd_addr    (sr[A_LSB +: ADDR_W]),
      .upd_data    (sr[D_LSB +: DATA_W]),
      .upd_op      (sr[OP_W-1:0]),
      .stat_clr    (stat_clr),
      .resp_valid  (resp_valid),
      .resp_data   (resp_data),
      .resp_status (resp_status),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .hold_data   (hold_w),
      .status      (sticky_w),
      .pending     (pending_w)
   );
endmodule

// File: rtl/dmi_access_chk.sv
module dmi_access_chk #(
   parameter int AW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tlr,
   input logic          sel,
   input logic          update,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic          pending,
   input logic [1:0]    sticky
);
   p_req_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);

   p_req_after_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(update && sel));

   p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(sel));

   p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !$past(pending));

   p_tlr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tlr |=> (!pending && sticky == 2'd0));

   p_addr_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> $stable(req_addr));
endmodule

bind dmi_access_reg dmi_access_chk #(.AW(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tlr       (tlr),
   .sel       (dmi_sel),
   .update    (update_dr),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .pending   (pending_w),
   .sticky    (sticky_w)
);

// File: tb/tb_dmi_access_reg.sv
module tb_dmi_access_reg;
   localparam int AW = 7;
   localparam int DW = 32;
   localparam int FW = AW + DW + 2;

   logic clk = 1'b0, rst_n = 1'b0, tlr = 1'b0, dmi_sel = 1'b0;
   logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
   logic stat_clr = 1'b0, resp_valid = 1'b0;
   logic [DW-1:0] resp_data = '0;
   logic [1:0] resp_status = '0;
   logic tdo, req_valid, req_write;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;

   int checks = 0, errors = 0;
   logic m_pend = 1'b0;
   logic [1:0] m_stat = 2'd0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_hold = '0;

   always #4 clk = ~clk;

   dmi_access_reg #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .tlr(tlr), .dmi_sel(dmi_sel),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .tdi(tdi), .tdo(tdo), .stat_clr(stat_clr),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_data(resp_data),
      .resp_status(resp_status));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] frame(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                           input logic [1:0] op);
      return {a, d, op};
   endfunction

   // full scan: capture, FW shifts, update; ends at the negedge after the update edge
   task automatic scan(input logic s, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [1:0] op);
      logic [FW-1:0] din, dout, exp;
      logic issue, acc, tdo0;
      din = frame(a, d, op);
      exp = {m_addr, m_hold, m_stat};
      tdo0 = tdo;
      dmi_sel = s;
      capture_dr = 1'b1;
      @(negedge clk);
      capture_dr = 1'b0;
      shift_dr = 1'b1;
      for (int i = 0; i < FW; i++) begin
         tdi = din[i];
         dout[i] = tdo;
         @(negedge clk);
      end
      shift_dr = 1'b0;
      update_dr = 1'b1;
      @(negedge clk);
      update_dr = 1'b0;
      if (s) begin
         chk("R4 R1 captured frame", 64'(dout), 64'(exp));
         acc = (op == 2'd1 || op == 2'd2);
         issue = acc && m_stat == 2'd0 && !m_pend;
         if (acc && m_stat == 2'd0 && m_pend) m_stat = 2'd3;
         if (issue) begin
            m_pend = 1'b1;
            m_addr = a;
            chk("R3 req_valid", 64'(req_valid), 64'd1);
            chk("R3 req_write", 64'(req_write), 64'(op == 2'd2));
            chk("R3 req_addr", 64'(req_addr), 64'(a));
            chk("R3 req_wdata", 64'(req_wdata), 64'(d));
         end else begin
            chk("R2 R7 no request", 64'(req_valid), 64'd0);
         end
      end else begin
         chk("R9 no request when deselected", 64'(req_valid), 64'd0);
         chk("R9 tdo unchanged when deselected", 64'(tdo), 64'(tdo0));
      end
      dmi_sel = 1'b0;
   endtask

   task automatic respond(input logic [DW-1:0] d, input logic [1:0] s);
      resp_valid = 1'b1;
      resp_data = d;
      resp_status = s;
      @(negedge clk);
      resp_valid = 1'b0;
      if (m_pend) begin
         m_pend = 1'b0;
         m_hold = d;
         if (s != 2'd0 && m_stat == 2'd0) m_stat = (s == 2'd1) ? 2'd2 : s;
      end
   endtask

   task automatic clear_status();
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      m_stat = 2'd0;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0007));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 reset tdo", 64'(tdo), 64'd0);
      chk("R3 reset req_valid", 64'(req_valid), 64'd0);

      // write to the bus address register, then a read whose data shows next scan
      scan(1'b1, 7'h39, 32'h1234_5678, 2'd2);
      respond(32'h0, 2'd0);
      scan(1'b1, 7'h11, 32'h0, 2'd1);
      respond(32'hCAFE_0001, 2'd0);
      scan(1'b1, 7'h00, 32'h0, 2'd0);            // R5: nop scan shows read data
      scan(1'b1, 7'h22, 32'hFFFF_FFFF, 2'd3);    // R2: op 3 is no request

      // R7: busy while outstanding, then everything dropped until cleared
      scan(1'b1, 7'h04, 32'h0, 2'd1);
      scan(1'b1, 7'h05, 32'hAAAA_5555, 2'd2);
      scan(1'b1, 7'h00, 32'h0, 2'd0);
      respond(32'hBEEF_0003, 2'd0);
      scan(1'b1, 7'h08, 32'h0, 2'd1);
      clear_status();

      // R6: reserved response recorded as failure
      scan(1'b1, 7'h06, 32'h0, 2'd1);
      respond(32'h0000_00D4, 2'd1);
      scan(1'b1, 7'h00, 32'h0, 2'd0);
      clear_status();

      // R10: stray response ignored
      respond(32'h5555_0005, 2'd2);
      scan(1'b1, 7'h00, 32'h0, 2'd0);

      // R9: deselected scan does nothing
      scan(1'b0, 7'h33, 32'h0000_0001, 2'd2);

      // R8: tlr with an operation outstanding
      scan(1'b1, 7'h07, 32'h0, 2'd1);
      chk("R8 tdo before tlr", 64'(tdo), 64'd1);
      tlr = 1'b1;
      @(negedge clk);
      tlr = 1'b0;
      m_pend = 1'b0;
      m_stat = 2'd0;
      chk("R8 tdo cleared by tlr", 64'(tdo), 64'd0);
      respond(32'h7777_7777, 2'd3);               // ignored: nothing outstanding
      scan(1'b1, 7'h0A, 32'h0, 2'd1);             // issues, so pending was cleared
      respond(32'h0000_000A, 2'd0);

      // random traffic
      for (int n = 0; n < 60; n++) begin
         logic [1:0] op, st;
         op = 2'($urandom_range(0, 3));
         scan(1'b1, 7'($urandom), 32'($urandom), op);
         if (m_pend) begin
            st = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            respond(32'($urandom), st);
         end
         if (m_stat != 2'd0 && $urandom_range(0, 1) == 1) clear_status();
      end
      scan(1'b1, 7'h00, 32'h0, 2'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule